// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the accumulator slice of a small 8-bit processor datapath. A combinational core works out, from the held accumulator, an operand byte, the held carry flag and a 3-bit operation code, both the next accumulator value and four status flags. The flags are zero, subtract, half-carry and carry. The operations are four single-bit accumulator rotates, plain subtract, subtract-with-borrow and exclusive-OR.

A registered wrapper holds the accumulator and the flags. It commits the core's result on any clock edge where the enable is high, so every operation finishes in one cycle. The carry input of the core is always the held carry flag. The accumulator can only be loaded through the operations themselves: after reset, an exclusive-OR with a byte places that byte in the accumulator.

Top module: `acc_alu_unit`

## Requirements
- R1: An active-low asynchronous reset clears the accumulator and all four flags to zero.
- R2: Code 0 (rotate left circular) moves accumulator bit 7 into bit 0 and into carry, and clears zero, subtract and half-carry, even when the result is 0x00.
- R3: Code 1 (rotate right circular) moves bit 0 into bit 7 and into carry, and clears zero, subtract and half-carry.
- R4: Code 2 (rotate left through carry) moves the old carry into bit 0 and bit 7 into carry, and clears the other three flags.
- R5: Code 3 (rotate right through carry) moves the old carry into bit 7 and bit 0 into carry, and clears the other three flags, even when the result is 0x00.
- R6: Code 4 (subtract) writes acc − operand truncated to 8 bits. It sets subtract. It sets zero when the result is 0x00, half-carry when the low nibble of acc is below the low nibble of the operand, and carry when acc is below the operand.
- R7: Code 5 (subtract with borrow) writes acc − (operand + carry) truncated to 8 bits, with the sum compared at 9 bits. Zero and subtract behave as for code 4. Half-carry is set when (acc & 0xF) < (operand & 0xF) + carry. Carry is set when acc < operand + carry. For example, 0x00 − (0xFF + 1) gives 0x00 with zero, subtract, half-carry and carry all set.
- R8: Code 6 (exclusive-OR) writes acc ^ operand, clears subtract, half-carry and carry, and sets zero only when the result is 0x00.
- R9: Code 7 is unused. With enable high it leaves the accumulator and all flags unchanged.
- R10: With enable low, the accumulator and flags keep their values whatever the code and operand are.
- R11: Each operation's result and flags are visible at the outputs right after the single clock edge at which enable was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Commit the selected operation at this edge |
| op | input | 3 | Operation code (0..6 used, 7 holds) |
| operand | input | DATA_W | Second operand byte |
| acc | output | DATA_W | Held accumulator |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Subtract flag |
| flag_h | output | 1 | Half-carry flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bench builds the block with its defaults: DATA_W of 8 and NIB_W of 4. Under these defaults the 9-bit borrow compare, the nibble half-borrow and the full wrap 0x00 − (0xFF + 1) are all reachable with byte values that can be checked by hand. Directed sequences chain the rotates through the held carry and reach zero results that the rotates must not flag. A pseudo-random run then mixes every code, including the unused one, with enable toggling, against a reference model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [2:0] {
        OP_ROT_LC = 3'd0,
        OP_ROT_RC = 3'd1,
        OP_ROT_LT = 3'd2,
        OP_ROT_RT = 3'd3,
        OP_SUB    = 3'd4,
        OP_SBB    = 3'd5,
        OP_XOR    = 3'd6,
        OP_RSV    = 3'd7
    } acc_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } acc_flags_t;

    function automatic logic op_is_rotate(acc_op_e op);
        return (op == OP_ROT_LC) || (op == OP_ROT_RC) ||
               (op == OP_ROT_LT) || (op == OP_ROT_RT);
    endfunction

endpackage

// File: rtl/acc_rotate_unit.sv
module acc_rotate_unit #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic              carry_in,
    input  logic              go_right,
    input  logic              via_carry,
    output logic [DATA_W-1:0] rot_out,
    output logic              carry_out
);
    logic fill_bit;

    always_comb begin
        if (!go_right) begin
            carry_out = a_in[DATA_W-1];
            fill_bit  = via_carry ? carry_in : a_in[DATA_W-1];
            rot_out   = {a_in[DATA_W-2:0], fill_bit};
        end else begin
            carry_out = a_in[0];
            fill_bit  = via_carry ? carry_in : a_in[0];
            rot_out   = {fill_bit, a_in[DATA_W-1:1]};
        end
    end
endmodule

// File: rtl/acc_borrow_sub.sv
module acc_borrow_sub #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              use_borrow,
    input  logic              borrow_in,
    output logic [DATA_W-1:0] diff_out,
    output logic              half_borrow,
    output logic              full_borrow
);
    localparam int EXT_W = DATA_W + 1;
    localparam int NEX_W = NIB_W + 1;

    logic              take;
    logic [EXT_W-1:0]  a_ext;
    logic [EXT_W-1:0]  sub_ext;
    logic [EXT_W-1:0]  diff_ext;
    logic [NEX_W-1:0]  a_nib;
    logic [NEX_W-1:0]  sub_nib;

    always_comb begin
        take     = use_borrow & borrow_in;
        a_ext    = {1'b0, a_in};
        sub_ext  = {1'b0, b_in} + EXT_W'(take);
        diff_ext = a_ext - sub_ext;
        diff_out = diff_ext[DATA_W-1:0];
        full_borrow = (a_ext < sub_ext);
        a_nib    = {1'b0, a_in[NIB_W-1:0]};
        sub_nib  = {1'b0, b_in[NIB_W-1:0]} + NEX_W'(take);
        half_borrow = (a_nib < sub_nib);
    end
endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] acc_cur,
    input  logic [DATA_W-1:0] opnd,
    input  acc_op_e           op_sel,
    input  acc_flags_t        flags_cur,
    output logic [DATA_W-1:0] acc_nxt,
    output acc_flags_t        flags_nxt
);
    logic [DATA_W-1:0] rot_res;
    logic              rot_cy;
    logic [DATA_W-1:0] sub_res;
    logic              sub_hb;
    logic              sub_fb;
    logic [DATA_W-1:0] xor_res;

    acc_rotate_unit #(.DATA_W(DATA_W)) u_rot (
        .a_in      (acc_cur),
        .carry_in  (flags_cur.c),
        .go_right  (op_sel[0]),
        .via_carry (op_sel[1]),
        .rot_out   (rot_res),
        .carry_out (rot_cy)
    );

    acc_borrow_sub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_sub (
        .a_in        (acc_cur),
        .b_in        (opnd),
        .use_borrow  (op_sel == OP_SBB),
        .borrow_in   (flags_cur.c),
        .diff_out    (sub_res),
        .half_borrow (sub_hb),
        .full_borrow (sub_fb)
    );

    always_comb begin
        xor_res   = acc_cur ^ opnd;
        acc_nxt   = acc_cur;
        flags_nxt = flags_cur;
        unique case (op_sel)
            OP_ROT_LC, OP_ROT_RC, OP_ROT_LT, OP_ROT_RT: begin
                acc_nxt   = rot_res;
                flags_nxt = '{z: 1'b0, n: 1'b0, h: 1'b0, c: rot_cy};
            end
            OP_SUB, OP_SBB: begin
                acc_nxt   = sub_res;
                flags_nxt = '{z: ~|sub_res, n: 1'b1, h: sub_hb, c: sub_fb};
            end
            OP_XOR: begin
                acc_nxt   = xor_res;
                flags_nxt = '{z: ~|xor_res, n: 1'b0, h: 1'b0, c: 1'b0};
            end
            default: begin
                acc_nxt   = acc_cur;
                flags_nxt = flags_cur;
            end
        endcase
    end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_h,
    output logic              flag_c
);
    typedef struct packed {
        logic [DATA_W-1:0] acc;
        acc_flags_t        flg;
    } acc_state_t;

    acc_state_t        st_d, st_q;
    acc_op_e           op_e;
    logic [DATA_W-1:0] dp_acc;
    acc_flags_t        dp_flg;

    assign op_e = acc_op_e'(op);

    acc_alu_datapath #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_dp (
        .acc_cur   (st_q.acc),
        .opnd      (operand),
        .op_sel    (op_e),
        .flags_cur (st_q.flg),
        .acc_nxt   (dp_acc),
        .flags_nxt (dp_flg)
    );

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.acc = dp_acc;
            st_d.flg = dp_flg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc    = st_q.acc;
    assign flag_z = st_q.flg.z;
    assign flag_n = st_q.flg.n;
    assign flag_h = st_q.flg.h;
    assign flag_c = st_q.flg.c;

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc) && $stable({flag_z, flag_n, flag_h, flag_c})); // R10
    AST_RSV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 3'd7) |=> $stable(acc) && $stable({flag_z, flag_n, flag_h, flag_c})); // R9
    AST_ROT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_is_rotate(op_e)) |=> !flag_z && !flag_n && !flag_h); // R2
    AST_RLC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 3'd0) |=> flag_c == acc[0] && acc[0] == $past(acc[DATA_W-1])); // R2
    AST_RRC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 3'd1) |=> flag_c == acc[DATA_W-1]); // R3
    AST_RL_CARRY_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 3'd2) |=> acc[0] == $past(flag_c)); // R4
    AST_RR_CARRY_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 3'd3) |=> acc[DATA_W-1] == $past(flag_c)); // R5
    AST_SUB_SETS_N: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (op == 3'd4 || op == 3'd5)) |=> flag_n && (flag_z == (acc == '0))); // R6
    AST_XOR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 3'd6) |=> !flag_n && !flag_h && !flag_c && (flag_z == (acc == '0))); // R8
endmodule

// File: tb/acc_alu_unit_tb.sv
`timescale 1ns/1ps
module acc_alu_unit_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [2:0]   op = 3'd0;
    logic [W-1:0] operand = '0;
    logic [W-1:0] acc;
    logic         flag_z, flag_n, flag_h, flag_c;

    acc_alu_unit u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .operand(operand),
        .acc(acc), .flag_z(flag_z), .flag_n(flag_n), .flag_h(flag_h), .flag_c(flag_c)
    );

    always #4 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [W+3:0] exp_q[$];
    int unsigned  due_q[$];
    string        tag_q[$];

    int m_a = 0, m_z = 0, m_n = 0, m_h = 0, m_c = 0;

    task automatic model_step(input int o, input int b);
        int d;
        case (o)
            0: begin d = ((m_a << 1) | (m_a >> 7)) & 255; m_c = m_a >> 7; m_a = d; m_z = 0; m_n = 0; m_h = 0; end
            1: begin d = (m_a >> 1) | ((m_a & 1) << 7); m_c = m_a & 1; m_a = d; m_z = 0; m_n = 0; m_h = 0; end
            2: begin d = ((m_a << 1) | m_c) & 255; m_c = m_a >> 7; m_a = d; m_z = 0; m_n = 0; m_h = 0; end
            3: begin d = (m_a >> 1) | (m_c << 7); m_c = m_a & 1; m_a = d; m_z = 0; m_n = 0; m_h = 0; end
            4: begin
                m_h = ((m_a & 15) < (b & 15)) ? 1 : 0;
                m_c = (m_a < b) ? 1 : 0;
                m_a = (m_a - b) & 255; m_z = (m_a == 0) ? 1 : 0; m_n = 1;
            end
            5: begin
                m_h = ((m_a & 15) < ((b & 15) + m_c)) ? 1 : 0;
                d   = m_a - (b + m_c);
                m_c = (m_a < (b + m_c)) ? 1 : 0;
                m_a = d & 255; m_z = (m_a == 0) ? 1 : 0; m_n = 1;
            end
            6: begin m_a = (m_a ^ b) & 255; m_z = (m_a == 0) ? 1 : 0; m_n = 0; m_h = 0; m_c = 0; end
            default: ;
        endcase
    endtask

    function automatic string tag_of(input int o, input bit e);
        if (!e) return "R10";
        case (o)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic drive(input int o, input int b, input bit e, input string tag);
        @(negedge clk);
        en = e; op = 3'(o); operand = W'(b);
        if (e) model_step(o, b);
        exp_q.push_back({W'(m_a), 1'(m_z), 1'(m_n), 1'(m_h), 1'(m_c)});
        due_q.push_back(cyc + 1);
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #1;
            while (due_q.size() > 0 && due_q[0] <= cyc) begin
                logic [W+3:0] e;
                logic [W+3:0] got;
                string t;
                e = exp_q.pop_front();
                void'(due_q.pop_front());
                t = tag_q.pop_front();
                got = {acc, flag_z, flag_n, flag_h, flag_c};
                n_cmp++;
                if (got !== e) begin
                    n_bad++;
                    $display("FAIL %s: acc/znhc actual %02h/%04b expected %02h/%04b",
                             t, got[W+3:4], got[3:0], e[W+3:4], e[3:0]);
                end
            end
        end
    end

    initial begin : watchdog
        #(8 * 20000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stimulus
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive(0, 0, 1'b0, "R1");              // reset state, all zero
        drive(6, 8'h80, 1'b1, "R8");          // load 0x80
        drive(0, 0, 1'b1, "R2");              // 0x01, C=1
        drive(2, 0, 1'b1, "R4");              // 0x03, C=0
        drive(6, 8'h03, 1'b1, "R8");          // 0x00, Z=1
        drive(0, 0, 1'b1, "R2");              // zero result, Z stays clear
        drive(6, 8'h01, 1'b1, "R8");
        drive(1, 0, 1'b1, "R3");              // 0x80, C=1
        drive(3, 0, 1'b1, "R5");              // 0xC0, C=0
        drive(3, 0, 1'b1, "R5");              // 0x60
        drive(6, 8'h61, 1'b1, "R8");          // 0x01
        drive(3, 0, 1'b1, "R5");              // 0x00, C=1, Z clear
        drive(5, 8'hFF, 1'b1, "R7");          // 0x00-(0xFF+1): Z,N,H,C
        drive(4, 8'h00, 1'b1, "R6");          // 0 - 0
        drive(6, 8'h10, 1'b1, "R8");
        drive(4, 8'h01, 1'b1, "R6");          // 0x0F, H=1
        drive(4, 8'h20, 1'b1, "R6");          // 0xEF, C=1
        drive(5, 8'h0F, 1'b1, "R7");          // 0xDF, H=1, C=0
        drive(6, 8'hFF, 1'b0, "R10");         // enable low holds
        drive(7, 8'h55, 1'b1, "R9");          // unused code holds
        drive(0, 0, 1'b1, "R11");             // single-cycle update
        lfsr = 16'hACE1;
        for (int i = 0; i < 80; i++) begin
            bit e;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            e = lfsr[5] | lfsr[6];
            drive(int'(lfsr[2:0]), int'(lfsr[15:8]), e, tag_of(int'(lfsr[2:0]), e));
        end
        @(negedge clk); en = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule